// File: doc/BRIEF.md
# Serial-In Shift Register with Latched Tri-State Outputs

The block collects a serial bit stream into a chain of shift stages and, on demand, copies the whole chain at once into a separate holding register. The holding register drives a parallel bus through per-bit tri-state drivers. The shift chain and the holding register each have their own clock. Software or a controller can therefore shift a new word in while the bus keeps showing the previous one. A strobe on the holding clock then updates every bus bit at the same moment.

The last shift stage is also brought out as a serial cascade output. Several instances can be chained to form a longer register, with each cascade output feeding the next instance's serial input. An active-low clear empties the shift chain only; the holding register keeps its value. An active-low output enable floats the parallel bus without touching the cascade output.

Top module: `shift_latch_bank`

## Requirements
- R1: On a rising edge of `shift_clk_i` while the chain is running, stage 0 takes `sdata_i` and every stage k (k>0) takes the former value of stage k-1.
- R2: On a rising edge of `latch_clk_i`, the holding register loads all shift stages in parallel, with holding bit k taken from stage k; `bus_o[k]` presents holding bit k.
- R3: `cascade_o` always equals the last shift stage, so after a shift it shows what the next-to-last stage held before.
- R4: Driving `clr_n_i` low clears every shift stage and `cascade_o` at once, without waiting for a clock, and leaves the holding register unchanged.
- R5: After `clr_n_i` returns high, the first SYNC_STAGES (default 2) rising edges of `shift_clk_i` leave the chain cleared; the next edge shifts normally.
- R6: While `out_en_n_i` is high every bit of `bus_o` is high impedance; while it is low `bus_o` shows the holding register. `cascade_o` is driven in both cases.
- R7: When both clocks rise on the same edge, the holding register captures the shift contents from before that edge, one shift behind the chain.
- R8: A holding-clock edge while `clr_n_i` is low loads all zeros into the holding register.
- R9: Two instances, with the first one's `cascade_o` wired to the second one's `sdata_i` and shared clocks, behave as one 2*WIDTH-stage shift register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_clk_i | input | 1 | Clock of the shift chain |
| latch_clk_i | input | 1 | Clock of the holding register |
| clr_n_i | input | 1 | Active-low clear of the shift chain, asserted asynchronously |
| sdata_i | input | 1 | Serial data into stage 0 |
| out_en_n_i | input | 1 | Active-low enable of the parallel bus drivers |
| cascade_o | output | 1 | Serial cascade output, copy of the last stage |
| bus_o | output | WIDTH | Parallel tri-state bus from the holding register |

## Verification
A wrong bit in the shift chain shows on `cascade_o` within WIDTH shift edges. It also shows on the bus at the first holding-clock strobe once the outputs are enabled. A wrong holding bit shows on the bus in the same cycle it is loaded, provided `out_en_n_i` is low. A clear that leaks into the holding register, or a release that comes out of reset one edge early or late, shows on the bus at the next strobe, because the reference model predicts every bit on every clock. A chained pair checks the cascade path. An error in the first instance's last stage reaches the second instance's stage 0 on the very next shift edge.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int unsigned SLB_DEF_WIDTH = 8;
  localparam int unsigned SLB_DEF_SYNC  = 2;
endpackage

// File: rtl/slb_rst_release.sv
module slb_rst_release #(
  parameter int unsigned SYNC_STAGES = slb_pkg::SLB_DEF_SYNC
) (
  input  logic clk_i,
  input  logic clr_n_i,
  output logic run_n_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_multi
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign run_n_o = sync_q[LAST];
endmodule

// File: rtl/slb_shift_chain.sv
module slb_shift_chain #(
  parameter int unsigned WIDTH = slb_pkg::SLB_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             run_n_i,
  input  logic             sdata_i,
  output logic [WIDTH-1:0] stage_o
);
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;

  genvar k;
  generate
    for (k = 0; k < WIDTH; k++) begin : g_stage
      if (k == 0) begin : g_head
        always_comb stage_d[k] = sdata_i;
      end else begin : g_body
        always_comb stage_d[k] = stage_q[k-1];
      end

      always_ff @(posedge clk_i or negedge run_n_i) begin
        if (!run_n_i) begin
          stage_q[k] <= 1'b0;
        end else begin
          stage_q[k] <= stage_d[k];
        end
      end
    end
  endgenerate

  assign stage_o = stage_q;
endmodule

// File: rtl/slb_hold_reg.sv
module slb_hold_reg #(
  parameter int unsigned WIDTH = slb_pkg::SLB_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] cap_i,
  output logic [WIDTH-1:0] hold_o
);
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;

  always_comb hold_d = cap_i;

  always_ff @(posedge clk_i) begin
    hold_q <= hold_d;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/slb_bus_drive.sv
module slb_bus_drive #(
  parameter int unsigned WIDTH = slb_pkg::SLB_DEF_WIDTH
) (
  input  logic             out_en_n_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] bus_o
);
  genvar k;
  generate
    for (k = 0; k < WIDTH; k++) begin : g_drv
      assign bus_o[k] = out_en_n_i ? 1'bz : data_i[k];
    end
  endgenerate
endmodule

// File: rtl/shift_latch_bank.sv
module shift_latch_bank #(
  parameter int unsigned WIDTH       = slb_pkg::SLB_DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = slb_pkg::SLB_DEF_SYNC
) (
  input  logic             shift_clk_i,
  input  logic             latch_clk_i,
  input  logic             clr_n_i,
  input  logic             sdata_i,
  input  logic             out_en_n_i,
  output logic             cascade_o,
  output logic [WIDTH-1:0] bus_o
);
  localparam int unsigned TAP = WIDTH - 1;

  logic             chain_run_n;
  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] hold_q;

  slb_rst_release #(.SYNC_STAGES(SYNC_STAGES)) u_rel (
    .clk_i   (shift_clk_i),
    .clr_n_i (clr_n_i),
    .run_n_o (chain_run_n)
  );

  slb_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i   (shift_clk_i),
    .run_n_i (chain_run_n),
    .sdata_i (sdata_i),
    .stage_o (shift_q)
  );

  slb_hold_reg #(.WIDTH(WIDTH)) u_hold (
    .clk_i  (latch_clk_i),
    .cap_i  (shift_q),
    .hold_o (hold_q)
  );

  slb_bus_drive #(.WIDTH(WIDTH)) u_drv (
    .out_en_n_i (out_en_n_i),
    .data_i     (hold_q),
    .bus_o      (bus_o)
  );

  assign cascade_o = shift_q[TAP];
endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
  parameter int unsigned WIDTH       = slb_pkg::SLB_DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = slb_pkg::SLB_DEF_SYNC
) (
  input logic             shift_clk_i,
  input logic             latch_clk_i,
  input logic             clr_n_i,
  input logic             sdata_i,
  input logic             out_en_n_i,
  input logic             cascade_o,
  input logic [WIDTH-1:0] bus_o,
  input logic             chain_run_n,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] hold_q
);
  // R1: stage 0 captures the serial input on a running shift edge
  a_r1_head_capture: assert property (@(posedge shift_clk_i) disable iff (!clr_n_i)
    chain_run_n |=> shift_q[0] == $past(sdata_i));

  // R3: cascade output shows the former next-to-last stage after a shift
  a_r3_cascade_tap: assert property (@(posedge shift_clk_i) disable iff (!clr_n_i)
    chain_run_n |=> cascade_o == $past(shift_q[WIDTH-2]));

  // R4: while clear is held the chain and cascade output are zero
  a_r4_clear_holds: assert property (@(posedge latch_clk_i)
    !clr_n_i |-> (shift_q == '0 && cascade_o == 1'b0));

  // R5: an edge taken before release completes leaves the chain empty
  a_r5_release_wait: assert property (@(posedge shift_clk_i) disable iff (!clr_n_i)
    !chain_run_n |=> shift_q == '0);

  // R6: enabled bus presents the holding register
  a_r6_bus_follows: assert property (@(posedge latch_clk_i) disable iff (!clr_n_i)
    !out_en_n_i |-> bus_o == hold_q);
endmodule

bind shift_latch_bank slb_checker #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .shift_clk_i (shift_clk_i),
  .latch_clk_i (latch_clk_i),
  .clr_n_i     (clr_n_i),
  .sdata_i     (sdata_i),
  .out_en_n_i  (out_en_n_i),
  .cascade_o   (cascade_o),
  .bus_o       (bus_o),
  .chain_run_n (chain_run_n),
  .shift_q     (shift_q),
  .hold_q      (hold_q)
);

// File: tb/shift_latch_bank_tb.sv
module shift_latch_bank_tb;
  localparam int W = 8;
  localparam int N = 2 * W;

  logic clk = 1'b0;
  logic sh_en = 1'b0;
  logic st_en = 1'b0;
  logic clr_n = 1'b1;
  logic sdata = 1'b0;
  logic oe_n = 1'b1;

  wire shift_clk = clk & sh_en;
  wire latch_clk = clk & st_en;

  wire         casc_a;
  wire         casc_b;
  wire [W-1:0] bus_a;
  wire [W-1:0] bus_b;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < W; i++) begin : g_pull
    pulldown (bus_a[i]);
    pullup   (bus_b[i]);
  end

  shift_latch_bank u_dut (
    .shift_clk_i (shift_clk), .latch_clk_i (latch_clk), .clr_n_i (clr_n),
    .sdata_i (sdata), .out_en_n_i (oe_n), .cascade_o (casc_a), .bus_o (bus_a)
  );

  shift_latch_bank u_dut2 (
    .shift_clk_i (shift_clk), .latch_clk_i (latch_clk), .clr_n_i (clr_n),
    .sdata_i (casc_a), .out_en_n_i (oe_n), .cascade_o (casc_b), .bus_o (bus_b)
  );

  // behavioural reference: one 16-bit queue plus two snapshots
  bit          mdl [N];
  bit [W-1:0]  hold_a;
  bit [W-1:0]  hold_b;
  bit          loaded = 1'b0;
  int          rel_left = 0;
  int          total = 0;
  int          fails = 0;
  bit          done = 1'b0;
  string       phase = "R4";
  int unsigned lfsr = 32'h1234_5678;

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("cascade first (R3)", int'(casc_a), int'(mdl[W-1]));
    chk("cascade second (R9)", int'(casc_b), int'(mdl[N-1]));
    if (oe_n) begin
      chk("bus first floating (R6)", int'(bus_a), 0);
      chk("bus second floating (R6)", int'(bus_b), (1 << W) - 1);
    end else if (loaded) begin
      chk("bus first (R2)", int'(bus_a), int'(hold_a));
      chk("bus second (R9)", int'(bus_b), int'(hold_b));
    end
  endtask

  task automatic step(input bit sh, input bit st, input bit din);
    @(negedge clk);
    compare();
    sh_en = sh;
    st_en = st;
    sdata = din;
    if (st) begin
      for (int n = 0; n < W; n++) begin
        hold_a[n] = mdl[n];
        hold_b[n] = mdl[W + n];
      end
      loaded = 1'b1;
    end
    if (sh && clr_n) begin
      if (rel_left > 0) begin
        rel_left--;
      end else begin
        for (int k = N - 1; k > 0; k--) mdl[k] = mdl[k-1];
        mdl[0] = din;
      end
    end
  endtask

  task automatic clear_on();
    @(negedge clk);
    compare();
    sh_en = 1'b0;
    st_en = 1'b0;
    clr_n = 1'b0;
    for (int k = 0; k < N; k++) mdl[k] = 1'b0;
    rel_left = 2;
    #1;
    compare();
  endtask

  task automatic clear_off();
    @(negedge clk);
    compare();
    sh_en = 1'b0;
    st_en = 1'b0;
    clr_n = 1'b1;
  endtask

  task automatic set_oe(input bit v);
    @(negedge clk);
    compare();
    sh_en = 1'b0;
    st_en = 1'b0;
    oe_n = v;
  endtask

  function automatic bit rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[0];
  endfunction

  initial begin
    #1;
    phase = "R4";
    clear_on();
    repeat (3) step(1'b0, 1'b0, 1'b0);
    // R6: bus floats from the start with outputs disabled
    phase = "R6";
    step(1'b0, 1'b0, 1'b0);
    clear_off();

    // R5: the first two shift edges after release are swallowed
    phase = "R5";
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    set_oe(1'b0);
    step(1'b0, 1'b0, 1'b0);

    // R1 / R2: shift a pattern, strobe, check the bus
    phase = "R1";
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, rnd());
    phase = "R2";
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);

    // R7: both clocks on the same edge
    phase = "R7";
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, rnd());
    step(1'b0, 1'b0, 1'b0);

    // R6: floating bus while shifting continues, cascade still driven
    phase = "R6";
    set_oe(1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    set_oe(1'b0);
    step(1'b0, 1'b0, 1'b0);

    // R4: clear mid-run leaves the holding register alone
    phase = "R4";
    clear_on();
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    // R8: strobe while clear is held loads zeros
    phase = "R8";
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    clear_off();

    // R9: long run through the chained pair
    phase = "R9";
    for (int i = 0; i < 48; i++) begin
      step(1'b1, (i % 7) == 6, rnd());
    end
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule